// File: doc/BRIEF.md
# Save-Area Page Permission Walker

This block checks, one page at a time, that every 4 KiB page a saved-state frame occupies may be used for a restore. A start pulse gives it the frame's linear base address, the extended-state size in bytes, the frame length in pages, the register-area size and the owner tag of the thread control page. The walker first visits each page from the frame base up to the page that holds byte `base + xsave_bytes`. It then visits the page that holds the register area, which sits at `base + 4096 * frame_pages - gpr_bytes`.

Each visit is a single lookup on a request/response port to an external page-attribute table. A page passes only if every attribute check succeeds. The physical page number returned for each passing page is appended to a list of up to `MAXP` entries. When all pages pass, `done` rises. On the first page that fails, the walk stops and `fault` rises with the offending linear address. Address translation is represented only by this port. Restoring the state is left to other logic.

Top module: `save_area_walker`

## Requirements
- R1: After reset `busy`, `done`, `fault`, `lk_req` and `ppn_count` are all 0.
- R2: The frame pages are looked up in ascending order at page-aligned addresses `base`, `base+4096`, … . There are `floor(xsave_bytes/4096)+1` of them. `lk_req` and `lk_addr` stay unchanged until `lk_rsp` arrives.
- R3: After the last frame page, exactly one more lookup is made, at the page containing `base + 4096*frame_pages - gpr_bytes`.
- R4: When every page passes, `done` rises and `busy` falls. `ppn_count` equals the frame page count plus one. List entry i (bits `[i*PW +: PW]` of `ppn_list`) holds the `lk_ppn` returned with the i-th response.
- R5: A response with `lk_miss`=1 faults the walk even if every attribute is good. After a fault no further lookup is issued.
- R6: A page faults when `lk_valid`=0, or when any of `lk_blocked`, `lk_pending` or `lk_modified` is 1.
- R7: A page faults when `lk_lin_page` differs from bits [AW-1:12] of the address being checked. It also faults when `lk_type` is not `REG_TYPE` (default 1).
- R8: A page faults when `lk_owner` differs from the `owner_id` latched at start.
- R9: A page faults when `lk_rd`=0 or `lk_wr`=0.
- R10: `fault_addr` is the page address for a frame page. For the register-area step it is the full register-area address. `ppn_count` gives the number of pages that passed before the fault.
- R11: A start whose page total (frame pages + 1) exceeds `MAXP` issues no lookup. It faults one cycle later with `fault_addr` set to the page-aligned base.
- R12: `start` is ignored while `busy`. An accepted start clears `done`, `fault`, `ppn_count` and every list entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| start | input | 1 | begin a walk (ignored while busy) |
| base_addr | input | AW | frame linear base; low 12 bits ignored |
| xsave_bytes | input | XW | extended-state size in bytes |
| frame_pages | input | FW | frame length in pages |
| gpr_bytes | input | GW | register-area size in bytes |
| owner_id | input | OW | owner tag of the control page |
| lk_req | output | 1 | lookup request pending |
| lk_addr | output | AW | page-aligned address being looked up |
| lk_rsp | input | 1 | lookup response valid |
| lk_miss | input | 1 | address does not resolve to protected memory |
| lk_valid | input | 1 | entry valid |
| lk_blocked | input | 1 | entry blocked |
| lk_pending | input | 1 | entry pending |
| lk_modified | input | 1 | entry modified |
| lk_lin_page | input | AW-12 | recorded linear page number |
| lk_type | input | TYW | page type |
| lk_owner | input | OW | owner tag of the page |
| lk_rd | input | 1 | read permitted |
| lk_wr | input | 1 | write permitted |
| lk_ppn | input | PW | physical page number |
| busy | output | 1 | walk in progress |
| done | output | 1 | all pages passed |
| fault | output | 1 | walk stopped on a failing page |
| fault_addr | output | AW | linear address of the failure |
| ppn_list | output | MAXP*PW | collected physical page numbers |
| ppn_count | output | CW | number of entries collected |

## Verification
The bench puts each kind of defect on the first frame page, on a middle page and on the register-area step. A design that mixed up the step order or the fault address would report the wrong address. A design that forgot a single conjunct would finish with `done` where it should fault. A miss carrying perfect attributes shows whether the miss test really comes first. One frame exactly fills the list, and one is a single page too big: an off-by-one there either overruns the list or refuses a legal frame. Further runs use a register-area page that lies outside the frame pages, responder latencies of up to three cycles, and a second start while busy. These catch an early step, a lost address, a restarted walk, and stale list entries left over from a longer previous run.

// File: rtl/save_area_walker.sv
module save_area_walker #(
  parameter int AW       = 32,
  parameter int PW       = 24,
  parameter int OW       = 8,
  parameter int TYW      = 3,
  parameter int XW       = 16,
  parameter int FW       = 4,
  parameter int GW       = 12,
  parameter int MAXP     = 8,
  parameter int REG_TYPE = 1,
  localparam int LPW     = AW - 12,
  localparam int CW      = $clog2(MAXP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     base_addr,
  input  logic [XW-1:0]     xsave_bytes,
  input  logic [FW-1:0]     frame_pages,
  input  logic [GW-1:0]     gpr_bytes,
  input  logic [OW-1:0]     owner_id,
  output logic              lk_req,
  output logic [AW-1:0]     lk_addr,
  input  logic              lk_rsp,
  input  logic              lk_miss,
  input  logic              lk_valid,
  input  logic              lk_blocked,
  input  logic              lk_pending,
  input  logic              lk_modified,
  input  logic [LPW-1:0]    lk_lin_page,
  input  logic [TYW-1:0]    lk_type,
  input  logic [OW-1:0]     lk_owner,
  input  logic              lk_rd,
  input  logic              lk_wr,
  input  logic [PW-1:0]     lk_ppn,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [AW-1:0]     fault_addr,
  output logic [MAXP*PW-1:0] ppn_list,
  output logic [CW-1:0]     ppn_count
);
  localparam int NW = XW - 11;
  localparam int IW = $clog2(MAXP);

  logic            walking, on_gpr, done_q, fault_q;
  logic [LPW-1:0]  cur_page;
  logic [NW-1:0]   left;
  logic [AW-1:0]   gpr_addr_q, faddr_q;
  logic [OW-1:0]   own_q;
  logic [CW-1:0]   cnt_q;
  logic [PW-1:0]   list_q [MAXP];

  logic [NW-1:0] nfr;
  logic          fits;
  logic [AW-1:0] base_al, gpr_calc, chk_addr;
  logic          page_ok;

  assign nfr      = NW'(xsave_bytes[XW-1:12]) + NW'(1);
  assign fits     = (32'(nfr) + 32'd1) <= 32'(MAXP);
  assign base_al  = {base_addr[AW-1:12], 12'h000};
  assign gpr_calc = base_al + (AW'(frame_pages) << 12) - AW'(gpr_bytes);
  assign chk_addr = on_gpr ? gpr_addr_q : {cur_page, 12'h000};

  assign page_ok = !lk_miss && lk_valid && !lk_blocked && !lk_pending && !lk_modified
                && (lk_lin_page == chk_addr[AW-1:12])
                && (lk_type == TYW'(REG_TYPE))
                && (lk_owner == own_q)
                && lk_rd && lk_wr;

  assign lk_req     = walking;
  assign lk_addr    = {chk_addr[AW-1:12], 12'h000};
  assign busy       = walking;
  assign done       = done_q;
  assign fault      = fault_q;
  assign fault_addr = faddr_q;
  assign ppn_count  = cnt_q;

  for (genvar g = 0; g < MAXP; g++) begin : g_list
    assign ppn_list[g*PW +: PW] = list_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      walking    <= 1'b0;
      on_gpr     <= 1'b0;
      done_q     <= 1'b0;
      fault_q    <= 1'b0;
      cur_page   <= '0;
      left       <= '0;
      gpr_addr_q <= '0;
      faddr_q    <= '0;
      own_q      <= '0;
      cnt_q      <= '0;
      for (int i = 0; i < MAXP; i++) list_q[i] <= '0;
    end else if (!walking) begin
      if (start) begin
        done_q     <= 1'b0;
        fault_q    <= 1'b0;
        cnt_q      <= '0;
        for (int i = 0; i < MAXP; i++) list_q[i] <= '0;
        own_q      <= owner_id;
        gpr_addr_q <= gpr_calc;
        cur_page   <= base_addr[AW-1:12];
        left       <= nfr;
        on_gpr     <= 1'b0;
        if (fits) begin
          walking <= 1'b1;
        end else begin
          fault_q <= 1'b1;
          faddr_q <= base_al;
        end
      end
    end else if (lk_rsp) begin
      if (!page_ok) begin
        fault_q <= 1'b1;
        faddr_q <= chk_addr;
        walking <= 1'b0;
      end else begin
        list_q[cnt_q[IW-1:0]] <= lk_ppn;
        cnt_q <= cnt_q + CW'(1);
        if (on_gpr) begin
          walking <= 1'b0;
          done_q  <= 1'b1;
        end else if (left == NW'(1)) begin
          on_gpr <= 1'b1;
        end else begin
          left     <= left - NW'(1);
          cur_page <= cur_page + LPW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/walker_chk.sv
module walker_chk #(
  parameter int AW   = 32,
  parameter int CW   = 4,
  parameter int MAXP = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          fault,
  input logic          lk_req,
  input logic          lk_rsp,
  input logic [AW-1:0] lk_addr,
  input logic [CW-1:0] ppn_count
);
  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && !lk_rsp) |=> (lk_req && $stable(lk_addr)));
  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!lk_req && !fault));
  // R5
  fault_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !lk_req);
  // R4
  done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (ppn_count >= CW'(2)));
  // R10
  list_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ppn_count) <= 32'(MAXP));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!busy && !done && !fault));
endmodule

bind save_area_walker walker_chk #(.AW(AW), .CW(CW), .MAXP(MAXP)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fault(fault),
  .lk_req(lk_req), .lk_rsp(lk_rsp), .lk_addr(lk_addr), .ppn_count(ppn_count)
);

// File: tb/sim_save_area_walker.sv
`timescale 1ns/1ps
module sim_save_area_walker;
  localparam int AW = 32, PW = 24, OW = 8, TYW = 3, XW = 16, FW = 4, GW = 12, MAXP = 8;
  localparam int CW = $clog2(MAXP + 1);
  localparam logic [OW-1:0] OWN = 8'h5C;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] base_addr = '0;
  logic [XW-1:0] xsave_bytes = '0;
  logic [FW-1:0] frame_pages = '0;
  logic [GW-1:0] gpr_bytes = '0;
  logic [OW-1:0] owner_id = OWN;
  logic lk_req, lk_rsp = 0, lk_miss = 0, lk_valid = 0, lk_blocked = 0, lk_pending = 0, lk_modified = 0;
  logic [AW-1:0] lk_addr;
  logic [AW-13:0] lk_lin_page = '0;
  logic [TYW-1:0] lk_type = '0;
  logic [OW-1:0] lk_owner = '0;
  logic lk_rd = 0, lk_wr = 0;
  logic [PW-1:0] lk_ppn = '0;
  logic busy, done, fault;
  logic [AW-1:0] fault_addr;
  logic [MAXP*PW-1:0] ppn_list;
  logic [CW-1:0] ppn_count;

  always #5 clk = ~clk;

  save_area_walker u0 (.*);

  int errors = 0, checks = 0;
  int bad_idx = 15, bad_kind = 0, lat = 0, wcnt = 0, nlog = 0;
  logic [AW-1:0] log_addr [16];

  function automatic logic [PW-1:0] ppn_of(input logic [AW-1:0] a);
    return {4'hC, a[31:12] ^ 20'h0F0F0};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    lk_rsp = 0;
    if (rst_n && lk_req) begin
      if (wcnt < lat) wcnt++;
      else begin
        wcnt = 0;
        lk_rsp = 1; lk_miss = 0; lk_valid = 1; lk_blocked = 0; lk_pending = 0; lk_modified = 0;
        lk_lin_page = lk_addr[31:12]; lk_type = 3'd1; lk_owner = OWN; lk_rd = 1; lk_wr = 1;
        lk_ppn = ppn_of(lk_addr);
        if (nlog == bad_idx) begin
          case (bad_kind)
            1: lk_miss = 1;
            2: lk_valid = 0;
            3: lk_blocked = 1;
            4: lk_pending = 1;
            5: lk_modified = 1;
            6: lk_lin_page = lk_addr[31:12] + 20'd1;
            7: lk_type = 3'd2;
            8: lk_owner = OWN ^ 8'h01;
            9: lk_rd = 0;
            10: lk_wr = 0;
            default: ;
          endcase
        end
        if (nlog < 16) log_addr[nlog] = lk_addr;
        nlog++;
      end
    end
  end

  typedef struct packed {
    logic [15:0] xs;
    logic [3:0]  fp;
    logic [11:0] gb;
    logic [3:0]  bi;
    logic [3:0]  bk;
    logic [1:0]  lt;
  } vec_t;
  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 4'd1, 12'h0B8, 4'd15, 4'd0,  2'd0},
    '{16'h2A40, 4'd4, 12'h0B8, 4'd15, 4'd0,  2'd1},
    '{16'h5FFF, 4'd6, 12'h100, 4'd15, 4'd0,  2'd2},
    '{16'h6000, 4'd7, 12'h100, 4'd15, 4'd0,  2'd0},
    '{16'h7000, 4'd8, 12'h100, 4'd15, 4'd0,  2'd0},
    '{16'h1000, 4'd2, 12'h0B8, 4'd0,  4'd1,  2'd0},
    '{16'h1000, 4'd2, 12'h0B8, 4'd1,  4'd2,  2'd1},
    '{16'h1000, 4'd2, 12'h0B8, 4'd2,  4'd3,  2'd0},
    '{16'h1000, 4'd2, 12'h0B8, 4'd0,  4'd4,  2'd0},
    '{16'h1000, 4'd2, 12'h0B8, 4'd1,  4'd5,  2'd2},
    '{16'h1000, 4'd2, 12'h0B8, 4'd2,  4'd6,  2'd0},
    '{16'h1000, 4'd2, 12'h0B8, 4'd1,  4'd7,  2'd0},
    '{16'h1000, 4'd2, 12'h0B8, 4'd2,  4'd8,  2'd1},
    '{16'h1000, 4'd2, 12'h0B8, 4'd0,  4'd9,  2'd0},
    '{16'h1000, 4'd2, 12'h0B8, 4'd2,  4'd10, 2'd0},
    '{16'h3000, 4'd5, 12'h200, 4'd4,  4'd1,  2'd0},
    '{16'h3000, 4'd5, 12'h200, 4'd2,  4'd9,  2'd0},
    '{16'h0800, 4'd3, 12'h0B8, 4'd15, 4'd0,  2'd3}
  };

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_end();
    for (int k = 0; k < 200 && !(done || fault); k++) @(negedge clk);
  endtask

  task automatic run_vec(input int v, input logic [AW-1:0] base);
    int nfr, total, stop;
    logic [AW-1:0] gaddr, step_a, exp_fa;
    logic exp_done;
    base_addr = base; xsave_bytes = VECS[v].xs; frame_pages = VECS[v].fp; gpr_bytes = VECS[v].gb;
    bad_idx = VECS[v].bi; bad_kind = VECS[v].bk; lat = VECS[v].lt; nlog = 0; wcnt = 0;
    nfr = int'(VECS[v].xs[15:12]) + 1;
    total = nfr + 1;
    gaddr = base + (32'(VECS[v].fp) << 12) - 32'(VECS[v].gb);
    pulse_start();
    wait_end();
    @(negedge clk);
    if (total > MAXP) begin
      chk(fault && !done, $sformatf("R11 vec%0d outcome", v), {fault, done}, 2'b10);
      chk(fault_addr == base, $sformatf("R11 vec%0d fault_addr", v), fault_addr, base);
      chk(nlog == 0, $sformatf("R11 vec%0d lookups", v), nlog, 0);
      return;
    end
    exp_done = (bad_idx >= total);
    stop = exp_done ? total : bad_idx + 1;
    chk(done == exp_done && fault == !exp_done,
        $sformatf("R4/R5/R6/R7/R8/R9 vec%0d kind%0d outcome", v, bad_kind), {done, fault}, {exp_done, !exp_done});
    chk(nlog == stop, $sformatf("R5 vec%0d lookup count", v), nlog, stop);
    for (int i = 0; i < stop && i < 16; i++) begin
      step_a = (i < nfr) ? base + 32'(i) * 32'h1000 : {gaddr[31:12], 12'h000};
      chk(log_addr[i] == step_a, $sformatf("R2/R3 vec%0d step%0d addr", v, i), log_addr[i], step_a);
    end
    chk(int'(ppn_count) == stop - (exp_done ? 0 : 1), $sformatf("R10 vec%0d count", v),
        ppn_count, stop - (exp_done ? 0 : 1));
    for (int i = 0; i < int'(ppn_count); i++) begin
      step_a = (i < nfr) ? base + 32'(i) * 32'h1000 : gaddr;
      chk(ppn_list[i*PW +: PW] == ppn_of(step_a), $sformatf("R4 vec%0d entry%0d", v, i),
          ppn_list[i*PW +: PW], ppn_of(step_a));
    end
    if (!exp_done) begin
      exp_fa = (bad_idx < nfr) ? base + 32'(bad_idx) * 32'h1000 : gaddr;
      chk(fault_addr == exp_fa, $sformatf("R10 vec%0d fault_addr", v), fault_addr, exp_fa);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !done && !fault && !lk_req && ppn_count == 0, "R1 reset state",
        {busy, done, fault, lk_req}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !lk_req, "R1 idle after reset", {busy, lk_req}, 0);

    for (int v = 0; v < NV; v++) run_vec(v, 32'h4000_0000 + 32'(v) * 32'h0010_0000);

    // R12: start while busy is ignored
    xsave_bytes = 16'h2000; frame_pages = 4'd3; gpr_bytes = 12'h0B8;
    base_addr = 32'h7700_0000; bad_idx = 15; bad_kind = 0; lat = 3; nlog = 0; wcnt = 0;
    pulse_start();
    repeat (2) @(negedge clk);
    base_addr = 32'h1100_0000; start = 1;
    @(negedge clk); start = 0;
    wait_end();
    @(negedge clk);
    chk(done && nlog == 4, "R12 busy start ignored outcome", nlog, 4);
    chk(log_addr[3] == 32'h7700_2000, "R12 busy start ignored addr", log_addr[3], 32'h7700_2000);

    // R12: short run after long run clears old entries
    xsave_bytes = 16'h0000; frame_pages = 4'd1; base_addr = 32'h2200_0000; lat = 0; nlog = 0;
    pulse_start();
    wait_end();
    @(negedge clk);
    chk(done && ppn_count == 2, "R12 short run count", ppn_count, 2);
    for (int i = 2; i < MAXP; i++)
      chk(ppn_list[i*PW +: PW] == '0, $sformatf("R12 stale entry%0d cleared", i), ppn_list[i*PW +: PW], 0);

    // R12: start after fault clears fault flag
    bad_idx = 0; bad_kind = 1; nlog = 0;
    pulse_start(); wait_end(); @(negedge clk);
    bad_idx = 15; bad_kind = 0; nlog = 0;
    pulse_start();
    chk(!fault, "R12 fault cleared by start", fault, 0);
    wait_end(); @(negedge clk);
    chk(done && !fault, "R12 clean run after fault", {done, fault}, 2'b10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule